// File: doc/BRIEF.md
# Serial Receive Path with Threshold-Signalled Queue

This block is the receive half of an asynchronous serial port. It oversamples the incoming line with a clock enable that pulses sixteen times per bit. It rebuilds each character from the framing settings it is given: word length, parity on or off, odd, even or fixed parity. Each finished character goes into a small first-in first-out queue, which the host drains through a read port.

Two interrupt outputs serve the host. One fires when the queue holds at least a programmable number of bytes. The other fires when the most recent character arrived with a parity, framing or break condition, or was lost to a full queue. A flush pulse empties the queue without disturbing a character that is still arriving. With the queue disabled, the block behaves as a single holding register.

Top module: `serial_rx_queue`

## Requirements
- R1: Data bits are taken least significant first. `word_len` 00/01/10/11 selects 5/6/7/8 bits, and unused upper bits of `rx_byte` read as 0.
- R2: A low level is accepted as a start bit only if it is still low at the 8th tick after detection. A shorter low pulse produces no character and changes no flag.
- R3: With `parity_on`=1, the expected parity bit is: even parity (XOR of the data bits) when `parity_even`=1 and `parity_stick`=0; its inverse when `parity_even`=0 and `parity_stick`=0; fixed 0 when both are 1; fixed 1 when `parity_stick`=1 and `parity_even`=0. A mismatch sets `err_parity`.
- R4: A stop bit sampled as 0 sets `err_frame`. If the data bits, the parity bit (when enabled) and the stop bit are all 0, `err_break` is also set. After such a character, the receiver waits for the line to return high before it looks for a new start bit.
- R5: Bytes leave the queue in arrival order. `rx_byte` shows the oldest byte, `pop` removes it, and `rx_ready` is 1 while the queue is not empty.
- R6: `trig_sel` 00/01/10/11 sets the threshold to 1/4/8/16 bytes. `avail_irq` is `avail_irq_en` AND (stored bytes ≥ threshold). With `fifo_mode`=0 the threshold is 1.
- R7: With `fifo_mode`=0, one byte is held. A second character that arrives while it is held is discarded and sets `err_overrun`.
- R8: With `fifo_mode`=1, a character that arrives while 16 bytes are stored is discarded and sets `err_overrun`. The stored bytes are unchanged.
- R9: `fifo_flush` discards all stored bytes. A character that is being received at the time is completed and stored.
- R10: The four error flags describe the most recently completed character and are replaced when the next one completes. `status_irq` is `status_irq_en` AND the OR of the flags.
- R11: After reset, `rx_ready`, all error flags and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | Oversampling enable, 16 per bit |
| word_len | input | 2 | Data bits: 00=5 … 11=8 |
| parity_on | input | 1 | Parity bit present |
| parity_even | input | 1 | Even parity select |
| parity_stick | input | 1 | Fixed parity select |
| fifo_mode | input | 1 | 1 = queue, 0 = single holding byte |
| trig_sel | input | 2 | Threshold code 1/4/8/16 |
| fifo_flush | input | 1 | Pulse: discard stored bytes |
| avail_irq_en | input | 1 | Enable for data interrupt |
| status_irq_en | input | 1 | Enable for error interrupt |
| pop | input | 1 | Remove oldest byte |
| rx_byte | output | 8 | Oldest stored byte |
| rx_ready | output | 1 | Queue not empty |
| err_parity | output | 1 | Last character had a parity mismatch |
| err_frame | output | 1 | Last character had stop bit 0 |
| err_break | output | 1 | Last character was a break |
| err_overrun | output | 1 | Last character was dropped |
| avail_irq | output | 1 | Data threshold interrupt |
| status_irq | output | 1 | Error interrupt |

## Verification
A receiver state machine that slips by one tick or takes one bit too many shows up as a shifted or wrong `rx_byte` and, usually, a false `err_frame` on the very character concerned. A wrong queue count appears at `avail_irq` as soon as the threshold is crossed, or as a missing or extra byte when the queue is drained. A lost flush or a bad overrun condition shows up at the next pop. Each of these faults therefore reaches a port within one character time, so every check is taken about two bit times after the last frame it depends on.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_t;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_char_t;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/rx_framer.sv
module rx_framer
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_s,
  input  logic       tick,
  input  logic [1:0] word_len,
  input  logic       par_on,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       done,
  output rx_char_t   ch
);
  localparam logic [3:0] MID_CNT = 4'd7;
  localparam logic [3:0] BIT_CNT = 4'd15;

  rx_state_t  st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] idx_q, idx_d;
  logic [7:0] sh_q, sh_d;
  logic       pb_q, pb_d;
  logic       done_d;
  rx_char_t   ch_d;
  logic [2:0] last_idx;
  logic       exp_par;

  assign last_idx = {1'b0, word_len} + 3'd4;
  assign exp_par  = par_stick ? ~par_even : (par_even ? ^sh_q : ~(^sh_q));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pb_d   = pb_q;
    done_d = 1'b0;
    ch_d   = ch;
    case (st_q)
      ST_IDLE: if (tick && !rx_s) begin
        st_d  = ST_START;
        cnt_d = '0;
      end
      ST_START: if (tick) begin
        if (cnt_q == MID_CNT) begin
          cnt_d = '0;
          idx_d = '0;
          sh_d  = '0;
          st_d  = rx_s ? ST_IDLE : ST_DATA;
        end else begin
          cnt_d = cnt_q + 4'd1;
        end
      end
      ST_DATA: if (tick) begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == BIT_CNT) begin
          sh_d[idx_q] = rx_s;
          if (idx_q == last_idx) st_d = par_on ? ST_PAR : ST_STOP;
          else                   idx_d = idx_q + 3'd1;
        end
      end
      ST_PAR: if (tick) begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == BIT_CNT) begin
          pb_d = rx_s;
          st_d = ST_STOP;
        end
      end
      ST_STOP: if (tick) begin
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == BIT_CNT) begin
          done_d    = 1'b1;
          ch_d.data = sh_q;
          ch_d.perr = par_on && (pb_q != exp_par);
          ch_d.ferr = !rx_s;
          ch_d.brk  = (sh_q == 8'h00) && !rx_s && (!par_on || !pb_q);
          st_d      = rx_s ? ST_IDLE : ST_HOLD;
        end
      end
      ST_HOLD: if (rx_s) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
      done  <= 1'b0;
      ch    <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      pb_q  <= pb_d;
      done  <= done_d;
      ch    <= ch_d;
    end
  end

  // R2
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && $past(st_q) == ST_IDLE) |-> $past(tick && !rx_s));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  hold_after_low_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ch.ferr) |-> (st_q == ST_HOLD || st_q == ST_IDLE));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          pop,
  input  logic          flush,
  input  logic          single,
  output logic [7:0]    rdata,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d, waddr;
  logic [CW-1:0] cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign waddr   = flush ? '0 : wp_q;
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = count;
    if (flush) begin
      rp_d  = '0;
      wp_d  = do_push ? AW'(1) : '0;
      cnt_d = do_push ? CW'(1) : '0;
    end else begin
      if (do_push) wp_d = nxt(wp_q);
      if (do_pop)  rp_d = nxt(rp_q);
      cnt_d = count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[waddr] <= wdata;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> count == $past(count));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count <= CW'(1));

  // R5
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && count != '0) |=> count == $past(count) - CW'(1));
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       baud_tick,
  input  logic [1:0] word_len,
  input  logic       parity_on,
  input  logic       parity_even,
  input  logic       parity_stick,
  input  logic       fifo_mode,
  input  logic [1:0] trig_sel,
  input  logic       fifo_flush,
  input  logic       avail_irq_en,
  input  logic       status_irq_en,
  input  logic       pop,
  output logic [7:0] rx_byte,
  output logic       rx_ready,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_break,
  output logic       err_overrun,
  output logic       avail_irq,
  output logic       status_irq
);
  logic [1:0]    rst_sync;
  logic          rst_i;
  logic [1:0]    rx_sync;
  logic          fr_done;
  rx_char_t      fr_ch;
  logic [CW-1:0] fill;
  logic          q_full;
  logic [CW-1:0] thr;
  logic [3:0]    flags_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rx_in};
  end

  rx_framer u_framer (
    .clk(clk), .rst_n(rst_i), .rx_s(rx_sync[1]), .tick(baud_tick),
    .word_len(word_len), .par_on(parity_on), .par_even(parity_even),
    .par_stick(parity_stick), .done(fr_done), .ch(fr_ch)
  );

  rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i), .push(fr_done), .wdata(fr_ch.data),
    .pop(pop), .flush(fifo_flush), .single(!fifo_mode),
    .rdata(rx_byte), .count(fill), .full(q_full)
  );

  always_comb begin
    flags_d = {err_parity, err_frame, err_break, err_overrun};
    if (fr_done) flags_d = {fr_ch.perr, fr_ch.ferr, fr_ch.brk, q_full};
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) {err_parity, err_frame, err_break, err_overrun} <= '0;
    else        {err_parity, err_frame, err_break, err_overrun} <= flags_d;
  end

  always_comb begin
    if (!fifo_mode)                          thr = CW'(1);
    else if (trig_level(trig_sel) > DEPTH)   thr = CW'(DEPTH);
    else                                     thr = CW'(trig_level(trig_sel));
  end

  assign rx_ready   = (fill != '0);
  assign avail_irq  = avail_irq_en && (fill >= thr);
  assign status_irq = status_irq_en &&
                      (err_parity || err_frame || err_break || err_overrun);

  // R10
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_i)
    fr_done |=> err_overrun == $past(q_full));

  // R6
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_i)
    avail_irq |-> rx_ready);
endmodule

// File: tb/serial_rx_queue_test.sv
module serial_rx_queue_test;
  localparam int TK   = 4;
  localparam int BITC = 16 * TK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1, baud_tick = 1'b0;
  logic [1:0] word_len = 2'd3, trig_sel = 2'd0;
  logic parity_on = 0, parity_even = 0, parity_stick = 0, fifo_mode = 1;
  logic fifo_flush = 0, avail_irq_en = 1, status_irq_en = 1, pop = 0;
  logic [7:0] rx_byte;
  logic rx_ready, err_parity, err_frame, err_break, err_overrun, avail_irq, status_irq;
  int total = 0, bad = 0, tcnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tcnt      <= (tcnt == TK - 1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == TK - 1);
  end

  serial_rx_queue uut (.*);

  // {word_len, parity_on, parity_even, parity_stick, flip_parity, stop_bit, data}
  localparam logic [14:0] VEC [10] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h2D},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h81},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7E},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h41},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_bit();
    repeat (BITC) @(negedge clk);
  endtask

  function automatic logic ref_par(input logic [7:0] d, input int nb,
                                   input logic even, input logic stick);
    logic x;
    x = ^(d & 8'((1 << nb) - 1));
    return stick ? !even : (even ? x : !x);
  endfunction

  task automatic send_char(input logic [7:0] d, input int nb, input logic pen,
                           input logic pbit, input logic stopv, input logic flush_mid);
    rx_in = 1'b0;
    wait_bit();
    for (int i = 0; i < nb; i++) begin
      rx_in = d[i];
      if (flush_mid && i == 2) begin
        @(negedge clk) fifo_flush = 1'b1;
        @(negedge clk) fifo_flush = 1'b0;
        repeat (BITC - 2) @(negedge clk);
      end else begin
        wait_bit();
      end
    end
    if (pen) begin
      rx_in = pbit;
      wait_bit();
    end
    rx_in = stopv;
    wait_bit();
    rx_in = 1'b1;
    wait_bit();
    wait_bit();
  endtask

  task automatic send8(input logic [7:0] d);
    send_char(d, 8, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk) fifo_flush = 1'b1;
    @(negedge clk) fifo_flush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11 ready", rx_ready, 0);
    check("R11 flags", {err_parity, err_frame, err_break, err_overrun}, 0);
    check("R11 irqs", {avail_irq, status_irq}, 0);

    // R1 R3 R4 R10 table walk
    foreach (VEC[k]) begin
      logic [7:0] d, m;
      int nb;
      logic pen, ev, st, fl, sv, pb, ep, ef, eb;
      d = VEC[k][7:0]; nb = int'(VEC[k][14:13]) + 5; pen = VEC[k][12];
      ev = VEC[k][11]; st = VEC[k][10]; fl = VEC[k][9]; sv = VEC[k][8];
      m  = 8'((1 << nb) - 1);
      pb = ref_par(d, nb, ev, st) ^ fl;
      word_len = VEC[k][14:13]; parity_on = pen; parity_even = ev; parity_stick = st;
      send_char(d, nb, pen, pb, sv, 1'b0);
      ep = pen & fl;
      ef = !sv;
      eb = ((d & m) == 8'h00) && !sv && (!pen || !pb);
      check("R5 ready after char", rx_ready, 1);
      check("R1 data bits", rx_byte, d & m);
      check("R3 parity flag", err_parity, ep);
      check("R4 frame flag", err_frame, ef);
      check("R4 break flag", err_break, eb);
      check("R10 status irq", status_irq, ep | ef | eb);
      do_pop();
      check("R5 empty after pop", rx_ready, 0);
    end
    word_len = 2'd3; parity_on = 0; parity_even = 0; parity_stick = 0;

    // R2 short low pulse
    send8(8'h11);
    do_pop();
    rx_in = 1'b0;
    repeat (5 * TK) @(negedge clk);
    rx_in = 1'b1;
    wait_bit(); wait_bit();
    check("R2 glitch no data", rx_ready, 0);
    check("R2 glitch no flags", {err_parity, err_frame, err_break, err_overrun}, 0);

    // R6 threshold levels
    trig_sel = 2'b01;
    for (int i = 0; i < 3; i++) send8(8'(8'h20 + i));
    check("R6 three below four", avail_irq, 0);
    send8(8'h23);
    check("R6 four reaches four", avail_irq, 1);
    trig_sel = 2'b10;
    #1 check("R6 four below eight", avail_irq, 0);
    trig_sel = 2'b00;
    #1 check("R6 level one", avail_irq, 1);
    avail_irq_en = 0;
    #1 check("R6 enable off", avail_irq, 0);
    avail_irq_en = 1;
    do_flush();
    check("R9 flush empties", rx_ready, 0);

    // R8 full queue
    trig_sel = 2'b11;
    for (int i = 0; i < 15; i++) send8(8'(8'h40 + i));
    check("R6 fifteen below sixteen", avail_irq, 0);
    send8(8'h4F);
    check("R6 sixteen reached", avail_irq, 1);
    check("R8 no overrun yet", err_overrun, 0);
    send8(8'hEE);
    check("R8 overrun flag", err_overrun, 1);
    check("R10 overrun irq", status_irq, 1);
    for (int i = 0; i < 16; i++) begin
      check("R8 R5 order kept", rx_byte, 8'(8'h40 + i));
      do_pop();
    end
    check("R8 dropped byte absent", rx_ready, 0);

    // R7 holding register mode
    fifo_mode = 0;
    send8(8'h5A);
    check("R7 first held", err_overrun, 0);
    send8(8'hA5);
    check("R7 second overrun", err_overrun, 1);
    check("R7 held byte", rx_byte, 8'h5A);
    do_pop();
    check("R7 only one held", rx_ready, 0);
    fifo_mode = 1;

    // R9 flush during reception
    trig_sel = 2'b00;
    send8(8'h31);
    send_char(8'hC6, 8, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R9 new char kept", rx_byte, 8'hC6);
    do_pop();
    check("R9 old char gone", rx_ready, 0);

    // R10 enable gating
    status_irq_en = 0;
    parity_on = 1; parity_even = 1;
    send_char(8'h01, 8, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R10 flag set", err_parity, 1);
    check("R10 irq masked", status_irq, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule